// File: doc/BRIEF.md
# Shared-Counter Edge-Aligned PWM Timer

The block is a register-mapped PWM timer. One up-counter, clocked through a power-of-two prescaler, is shared by every output channel. Each channel compares the shared count with its own duty value and drives one edge-aligned PWM pin. All channels therefore have the same period, which is set by a common modulo register. Only the duty value and the output polarity belong to a single channel.

Software drives the block through a 32-bit register port with separate write and read strobes. The port has no stream data path, so it has no valid/ready handshake. A write takes effect on the clock edge where `wr_en` is high. A read returns data one cycle after the `rd_en` cycle, and the port never stalls. Modulo and duty writes go into shadow registers. While the counter runs, the shadows reach the counter and comparators only when the count wraps, so a period is never cut short. While the counter is stopped, they take effect at once.

Each channel has a sticky match flag that is cleared by writing one to it. A channel's output can be silenced by clearing its two level bits, and the shared counter keeps running.

Top module: `pwm_shared_timer`

## Requirements
- R1: Register offsets: 0x08 reads 0 and ignores writes; 0x10 control; 0x14 count (read-only); 0x18 modulo; channel n control at 0x20+8n and duty at 0x24+8n. After reset, modulo reads 0xFFFF, every other register reads 0, and all PWM outputs are 0.
- R2: Control bits [2:0] hold the prescale exponent PS and bits [4:3] hold the clock mode. The counter runs only when the mode is 01; any other mode freezes it. Bit 5 (up-down select) is not stored and reads 0, because only up-counting exists.
- R3: The counter advances once every 2^PS clocks. It counts from 0 up to the modulo value inclusive and then returns to 0, so one period is (modulo+1)·2^PS clocks.
- R4: Register 0x14 returns the current count. A frozen counter keeps its value.
- R5: Channel control layout: bit 7 match flag, bit 5 mode-B, bit 4 mode-A, bit 3 level-B, bit 2 level-A. The other bits read 0. Edge-aligned PWM is selected by mode-B=1 with mode-A=0.
- R6: With level-B=1 (normal polarity), the output is 1 while count < duty and 0 otherwise, giving duty·2^PS high clocks per period.
- R7: With level-A=1 and level-B=0, the output is the complement of the normal waveform. When both level bits are 1, normal polarity is used.
- R8: When both level bits are 0, or when the channel is not in PWM mode, the output is 0. The shared counter keeps running in this case.
- R9: A duty value of 0 holds the output at its inactive level. A duty value greater than the modulo holds it at its active level.
- R10: The match flag is set on every cycle where the counter runs and equals the channel's active duty value, in any channel mode. Writing 1 to bit 7 clears the flag; writing 0 there leaves it unchanged. A set in the same cycle as a clear wins. Writing 0x80 also clears the mode and level bits.
- R11: Modulo and duty writes read back at once. While the counter runs, they take effect at the next wrap. While it is stopped, they take effect immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock, the only timing source |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset for both reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| pwm_out | output | NUM_CH | Registered PWM outputs, one per channel |

## Verification
The bench builds the block with its defaults: two channels, a 16-bit counter and a 3-bit prescale field. This lets it compare two channels with opposite polarity on the same counter. It also reaches the largest divide of 128 and a full 65536-count wrap of the reset-time modulo, which is where a shadowed duty write finally lands. Short modulo values such as 1, 3, 9 and 199 keep the duty measurements to a few hundred clocks, and each measurement counts high cycles over whole periods.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int OFF_GLOBAL  = 'h08;
  localparam int OFF_CTRL    = 'h10;
  localparam int OFF_COUNT   = 'h14;
  localparam int OFF_MODULO  = 'h18;
  localparam int OFF_CH_CTRL = 'h20;
  localparam int OFF_CH_DUTY = 'h24;
  localparam int CH_STRIDE   = 8;

  localparam logic [1:0] MODE_RUN = 2'b01;

  typedef struct packed {
    logic clr;
    logic msb;
    logic msa;
    logic lvb;
    logic lva;
  } chan_wr_t;

  typedef struct packed {
    logic flag;
    logic msb;
    logic msa;
    logic lvb;
    logic lva;
  } chan_rd_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit = ~({DIV_W{1'b1}} << ps);
  assign tick  = run && (div_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    div_q <= '0;
    else if (!run) div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + DIV_W'(1);
  end

  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (div_q == '0)); // R3

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             wr_mod,
  input  logic [CNT_W-1:0] wdata_mod,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] mod_rd,
  output logic             load
);
  logic [CNT_W-1:0] cnt_q, mod_sh, mod_act;
  logic             wrap;

  assign wrap   = tick && (cnt_q >= mod_act);
  assign load   = wrap || !run;
  assign cnt    = cnt_q;
  assign mod_rd = mod_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mod_sh  <= '1;
      mod_act <= '1;
    end else begin
      if (wr_mod) mod_sh <= wdata_mod;
      if (load)   mod_act <= mod_sh;
      if (tick)   cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q >= mod_act) |=> (cnt_q == '0)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_ctrl,
  input  chan_wr_t         cfg,
  input  logic             wr_duty,
  input  logic [CNT_W-1:0] wdata_duty,
  output chan_rd_t         ctrl_rd,
  output logic [CNT_W-1:0] duty_rd,
  output logic             pwm_o
);
  logic             msb_q, msa_q, lvb_q, lva_q, flag_q, pwm_q;
  logic [CNT_W-1:0] duty_sh, duty_act;
  logic             active, hit, raw;

  assign active = msb_q && !msa_q && (lvb_q || lva_q);
  assign hit    = run && (cnt == duty_act);
  assign raw    = cnt < duty_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msb_q    <= 1'b0;
      msa_q    <= 1'b0;
      lvb_q    <= 1'b0;
      lva_q    <= 1'b0;
      flag_q   <= 1'b0;
      duty_sh  <= '0;
      duty_act <= '0;
      pwm_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        msb_q <= cfg.msb;
        msa_q <= cfg.msa;
        lvb_q <= cfg.lvb;
        lva_q <= cfg.lva;
      end
      if (hit)                     flag_q <= 1'b1;
      else if (wr_ctrl && cfg.clr) flag_q <= 1'b0;
      if (wr_duty) duty_sh <= wdata_duty;
      if (load)    duty_act <= duty_sh;
      if (!active)    pwm_q <= 1'b0;
      else if (lvb_q) pwm_q <= raw;
      else            pwm_q <= !raw;
    end
  end

  assign ctrl_rd = '{flag: flag_q, msb: msb_q, msa: msa_q, lvb: lvb_q, lva: lva_q};
  assign duty_rd = duty_sh;
  assign pwm_o   = pwm_q;

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !pwm_q); // R8
  AST_ZERO_DUTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && duty_act == '0) |=> (pwm_q == !$past(lvb_q))); // R9
  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q); // R10

endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int MODE_LSB = PS_W;

  logic [PS_W-1:0]  ps_q;
  logic [1:0]       mode_q;
  logic             run, tick, load;
  logic [CNT_W-1:0] cnt, mod_rd;
  logic [31:0]      rd_next, rd_q;
  logic             wr_ctrl, wr_mod;

  logic [NUM_CH-1:0] wr_ch_ctrl, wr_ch_duty;
  chan_rd_t          ch_ctrl_rd [NUM_CH];
  logic [CNT_W-1:0]  ch_duty_rd [NUM_CH];
  chan_wr_t          cfg;

  logic unused_bits;
  assign unused_bits = ^{wr_data[31:CNT_W], wr_data[6], wr_data[1:0]};

  assign run     = (mode_q == MODE_RUN);
  assign wr_ctrl = wr_en && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_mod  = wr_en && (bus_addr == ADDR_W'(OFF_MODULO));
  assign cfg     = '{clr: wr_data[7], msb: wr_data[5], msa: wr_data[4],
                     lvb: wr_data[3], lva: wr_data[2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q   <= '0;
      mode_q <= 2'b00;
    end else if (wr_ctrl) begin
      ps_q   <= wr_data[PS_W-1:0];
      mode_q <= wr_data[MODE_LSB+1:MODE_LSB];
    end
  end

  pwm_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .ps(ps_q), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .wr_mod(wr_mod), .wdata_mod(wr_data[CNT_W-1:0]),
    .cnt(cnt), .mod_rd(mod_rd), .load(load)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign wr_ch_ctrl[g] = wr_en && (bus_addr == ADDR_W'(OFF_CH_CTRL + g*CH_STRIDE));
    assign wr_ch_duty[g] = wr_en && (bus_addr == ADDR_W'(OFF_CH_DUTY + g*CH_STRIDE));

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run), .load(load), .cnt(cnt),
      .wr_ctrl(wr_ch_ctrl[g]), .cfg(cfg),
      .wr_duty(wr_ch_duty[g]), .wdata_duty(wr_data[CNT_W-1:0]),
      .ctrl_rd(ch_ctrl_rd[g]), .duty_rd(ch_duty_rd[g]), .pwm_o(pwm_out[g])
    );
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL))
      rd_next = 32'({mode_q, ps_q});
    else if (bus_addr == ADDR_W'(OFF_COUNT))
      rd_next = 32'(cnt);
    else if (bus_addr == ADDR_W'(OFF_MODULO))
      rd_next = 32'(mod_rd);
    else if (bus_addr == ADDR_W'(OFF_GLOBAL))
      rd_next = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(OFF_CH_CTRL + i*CH_STRIDE))
        rd_next = 32'({ch_ctrl_rd[i].flag, 1'b0, ch_ctrl_rd[i].msb, ch_ctrl_rd[i].msa,
                       ch_ctrl_rd[i].lvb, ch_ctrl_rd[i].lva, 2'b00});
      if (bus_addr == ADDR_W'(OFF_CH_DUTY + i*CH_STRIDE))
        rd_next = 32'(ch_duty_rd[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_next;
  end

  assign rd_data = rd_q;

  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick); // R2

endmodule

// File: tb/sim_pwm_shared_timer.sv
`timescale 1ns/1ps
module sim_pwm_shared_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [1:0]  pwm_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  logic [31:0] mask_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic [31:0] last_rd = '0;

  always #10 clk = ~clk;

  pwm_shared_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  // monitor: pops the expected read value and compares it
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e, m;
      string t;
      e = exp_q.pop_front();
      m = mask_q.pop_front();
      t = tag_q.pop_front();
      last_rd = rd_data;
      if (m != 0) begin
        n_checks++;
        if ((rd_data & m) !== (e & m)) begin
          n_errors++;
          $display("FAIL %s: read got 0x%08h expected 0x%08h (mask 0x%08h)", t, rd_data, e, m);
        end
      end
    end
  end

  task automatic chk(input int act, input int expv, input string tag);
    n_checks++;
    if (act != expv) begin
      n_errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e,
                        input logic [31:0] m, input string tag);
    @(negedge clk);
    exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(tag);
    bus_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_cap(input logic [7:0] a, output logic [31:0] v);
    rd_exp(a, 32'h0, 32'h0, "capture");
    v = last_rd;
  endtask

  task automatic count_high(input int ch, input int ncyc, output int n);
    n = 0;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) n++;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int h, h0, h1, bad;
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(int'(pwm_out), 0, "R1 outputs after reset");
    rd_exp(8'h10, 32'h0, '1, "R1 control reset");
    rd_exp(8'h14, 32'h0, '1, "R1 count reset");
    rd_exp(8'h18, 32'hFFFF, '1, "R1 modulo reset");
    rd_exp(8'h20, 32'h0, '1, "R1 ch0 ctrl reset");
    rd_exp(8'h24, 32'h0, '1, "R1 ch0 duty reset");
    rd_exp(8'h28, 32'h0, '1, "R1 ch1 ctrl reset");
    rd_exp(8'h2C, 32'h0, '1, "R1 ch1 duty reset");
    wr(8'h08, 32'hFFFF_FFFF);
    rd_exp(8'h08, 32'h0, '1, "R1 global reads 0");

    // R11 shadowing across a full 65536 wrap
    wr(8'h20, 32'h28);
    wr(8'h10, 32'h28);                       // bit5 set, mode 01
    rd_exp(8'h10, 32'h08, '1, "R2 bit5 not stored");
    repeat (20) @(negedge clk);
    wr(8'h24, 32'd50);
    wr(8'h18, 32'd199);
    rd_exp(8'h24, 32'd50, '1, "R11 duty readback");
    rd_exp(8'h18, 32'd199, '1, "R11 modulo readback");
    count_high(0, 500, h);
    chk(h, 0, "R11 old duty kept before wrap");
    rd_cap(8'h14, v);
    chk(int'(v >= 500 && v < 1000), 1, "R3 counter advancing past old period");
    repeat (66000) @(negedge clk);
    count_high(0, 400, h);
    chk(h, 100, "R11 R6 new duty after wrap");
    rd_cap(8'h14, v);
    chk(int'(v <= 199), 1, "R3 count within new modulo");

    // R10 flag behaviour
    wr(8'h10, 32'h0);
    rd_exp(8'h20, 32'hA8, '1, "R10 ch0 flag set");
    rd_exp(8'h28, 32'h80, '1, "R10 ch1 flag set while output disabled");
    wr(8'h20, 32'h28);
    rd_exp(8'h20, 32'hA8, '1, "R10 zero in bit7 keeps flag");
    wr(8'h20, 32'hA8);
    rd_exp(8'h20, 32'h28, '1, "R10 one in bit7 clears flag");
    wr(8'h28, 32'h80);
    rd_exp(8'h28, 32'h0, '1, "R10 0x80 clears all");

    // R4 frozen counter
    rd_cap(8'h14, v);
    repeat (30) @(negedge clk);
    rd_exp(8'h14, v, '1, "R4 stopped count holds");

    // R6 R7 polarity, immediate load while stopped
    wr(8'h18, 32'd9);
    wr(8'h24, 32'd4);
    wr(8'h2C, 32'd4);
    wr(8'h28, 32'h24);
    wr(8'h10, 32'h08);
    repeat (40) @(negedge clk);
    count_high(0, 100, h0);
    chk(h0, 40, "R6 normal duty 4 of 10");
    count_high(1, 100, h1);
    chk(h1, 60, "R7 inverted duty 6 of 10");
    bad = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (pwm_out[0] == pwm_out[1]) bad++;
    end
    chk(bad, 0, "R7 inverted is complement");
    rd_exp(8'h28, 32'h24, 32'h7F, "R5 ch1 field layout");
    wr(8'h28, 32'h2C);
    repeat (3) @(negedge clk);
    count_high(1, 100, h1);
    chk(h1, 40, "R7 both level bits give normal");

    bad = 0;
    for (int k = 0; k < 20; k++) begin
      rd_cap(8'h14, v);
      if (v > 9) bad++;
    end
    chk(bad, 0, "R3 count never exceeds modulo");

    // R9 extremes (loaded at wrap while running)
    wr(8'h24, 32'd0);
    wr(8'h2C, 32'd20);
    repeat (30) @(negedge clk);
    count_high(0, 100, h0);
    chk(h0, 0, "R9 duty 0 inactive");
    count_high(1, 100, h1);
    chk(h1, 100, "R9 duty above modulo active");

    // R8 disabled outputs, counter unaffected
    wr(8'h24, 32'd5);
    repeat (30) @(negedge clk);
    wr(8'h20, 32'h20);
    wr(8'h28, 32'h38);
    repeat (3) @(negedge clk);
    count_high(0, 100, h0);
    chk(h0, 0, "R8 level bits clear gives 0");
    count_high(1, 100, h1);
    chk(h1, 0, "R8 R5 non-PWM mode gives 0");
    wr(8'h20, 32'h28);
    repeat (3) @(negedge clk);
    count_high(0, 100, h0);
    chk(h0, 50, "R8 counter kept running");
    wr(8'h20, 32'h80);
    repeat (3) @(negedge clk);
    count_high(0, 100, h0);
    chk(h0, 0, "R10 0x80 disables channel");
    rd_exp(8'h20, 32'h0, 32'h7F, "R10 0x80 clears mode and level");

    // R3 prescaler
    wr(8'h10, 32'h0);
    wr(8'h18, 32'd3);
    wr(8'h24, 32'd1);
    wr(8'h20, 32'h28);
    wr(8'h10, 32'h0A);
    repeat (40) @(negedge clk);
    count_high(0, 160, h);
    chk(h, 40, "R3 PS=2 high 4 of 16");
    wr(8'h10, 32'h0);
    wr(8'h18, 32'd1);
    wr(8'h10, 32'h0F);
    repeat (300) @(negedge clk);
    count_high(0, 512, h);
    chk(h, 256, "R3 PS=7 high 128 of 256");
    rd_exp(8'h10, 32'h0F, '1, "R2 control readback");
    wr(8'h10, 32'h17);
    rd_cap(8'h14, v);
    repeat (300) @(negedge clk);
    rd_exp(8'h14, v, '1, "R2 mode 10 freezes counter");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule